// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter with Sentinel End Detection

This block serialises one byte plus a host-chosen ninth bit into an eleven-bit asynchronous frame. The frame is a low start bit, the byte least significant bit first, the ninth bit, and a high stop bit. The host offers a frame with a one-cycle write strobe. The block does not start the frame at once. It waits for the next wrap of a free-running divide-by-16 counter that advances on a baud tick arriving at sixteen times the bit rate. Every bit edge on the line therefore lands on a counter wrap, whatever the phase of the write.

No bit counter marks the end of the frame. On its first shift the shift register takes in a single one, and after that it takes in zeros. The frame ends when that one sits just left of the output position with nothing but zeros above it. At that point the block shifts one last time, leaves the send phase, drops busy and raises a sticky completion flag. The host clears the flag with a dedicated input.

Top module: `uart9_tx`

## Requirements
- R1: After reset, txd is 1, busy is 0 and tx_done is 0.
- R2: While no frame is on the line, txd is 1. This covers the wait between an accepted write and the start bit, and the stop bit after completion.
- R3: A wr_en pulse while busy is 0 is accepted, and busy reads 1 from the next cycle. The start bit (txd 0) begins at the first divide-by-16 wrap after the write. A wrap is every 16th baud_tick counted from reset. The counter moves only on baud_tick and never stops, so a write made on a wrapping tick starts 16 ticks later.
- R4: The start bit is followed by wr_data bit 0 up to bit 7 and then wr_bit9. Each bit holds txd unchanged for exactly one bit time, from one wrap to the next.
- R5: At the 11th wrap after the accepted write, busy falls, tx_done rises and txd returns to 1 as the stop bit.
- R6: tx_done stays 1 until flag_clr is pulsed, and it reads 0 in the cycle after the pulse. Completion takes precedence over a clear in the same cycle.
- R7: A write while busy is 1 is ignored. The frame in progress keeps its original bits.
- R8: The end of the frame is found from the sentinel pattern alone, for any data and ninth bit, including all zeros and all ones. Busy stays 1 through the ninth-bit time and never ends early.
- R9: A write in the cycle after completion is accepted. Its start bit begins one full bit time (16 ticks) later, so the stop bit keeps its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Data byte to send |
| wr_bit9 | input | 1 | Ninth bit to send |
| flag_clr | input | 1 | Clears tx_done |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame requested or in progress |
| tx_done | output | 1 | Sticky transmit-complete flag |

## Verification
Busy follows an accepted write after one clock. Every line change and the completion flag follow the clocked edge of a wrapping baud tick. The flag clear takes effect one clock after its pulse. The bench drives inputs on the falling edge and counts baud ticks itself to know which tick wraps. It samples one half period after each rising edge and compares txd against the bit expected for the number of wraps seen since the write. It also checks that txd holds still on the ticks between wraps, and that the flag appears exactly at the 11th wrap.

// File: rtl/uart9_tx_pkg.sv
package uart9_tx_pkg;
  // send/data phase flags packed as {send, data}
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_START = 2'b10,
    PH_DATA  = 2'b11
  } tx_phase_e;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_DIV    = 16;
endpackage

// File: rtl/uart9_tx_bitclk.sv
module uart9_tx_bitclk #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  output logic roll
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  assign roll = baud_tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (baud_tick) cnt <= next_count(cnt);
  end
endmodule

// File: rtl/uart9_tx_shreg.sv
module uart9_tx_shreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_bit9,
  input  logic              shift_en,
  input  logic              fill,
  output logic [DATA_W:0]   sh,
  output logic              marker_hit
);
  localparam int unsigned SH_W = DATA_W + 1;

  function automatic logic [SH_W-1:0] shift_in(input logic [SH_W-1:0] v, input logic f);
    return {f, v[SH_W-1:1]};
  endfunction

  // ninth bit at output, sentinel one just left, zeros above
  function automatic logic sentinel_at_out(input logic [SH_W-1:0] v);
    return v[1] && (v[SH_W-1:2] == '0);
  endfunction

  assign marker_hit = sentinel_at_out(sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '1;
    else if (load)     sh <= {load_bit9, load_data};
    else if (shift_en) sh <= shift_in(sh, fill);
  end
endmodule

// File: rtl/uart9_tx_ctrl.sv
module uart9_tx_ctrl
  import uart9_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      roll,
  input  logic      wr_en,
  input  logic      flag_clr,
  input  logic      marker_hit,
  output logic      load,
  output logic      shift_en,
  output logic      fill,
  output tx_phase_e phase,
  output logic      shifted,
  output logic      busy,
  output logic      finish,
  output logic      tx_done
);
  logic req;

  assign busy     = req || (phase != PH_IDLE);
  assign load     = wr_en && !busy;
  assign shift_en = roll && (phase == PH_DATA);
  assign fill     = !shifted;
  assign finish   = shift_en && shifted && marker_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req     <= 1'b0;
      phase   <= PH_IDLE;
      shifted <= 1'b0;
    end else begin
      if (load) req <= 1'b1;
      if (roll) begin
        unique case (phase)
          PH_IDLE: if (req) begin
            phase   <= PH_START;
            req     <= 1'b0;
            shifted <= 1'b0;
          end
          PH_START: phase <= PH_DATA;
          PH_DATA: begin
            shifted <= 1'b1;
            if (shifted && marker_hit) phase <= PH_IDLE;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_done <= 1'b0;
    else if (finish)   tx_done <= 1'b1;
    else if (flag_clr) tx_done <= 1'b0;
  end
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_tx_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DIV    = DEF_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              flag_clr,
  output logic              txd,
  output logic              busy,
  output logic              tx_done
);
  logic            roll;
  logic            load;
  logic            shift_en;
  logic            fill;
  logic            shifted;
  logic            marker_hit;
  logic            finish;
  logic [DATA_W:0] sh;
  tx_phase_e       phase;
  logic            send;
  logic            data_ph;

  assign send    = phase[1];
  assign data_ph = phase[0];

  uart9_tx_bitclk #(.DIV(DIV)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .roll(roll)
  );

  uart9_tx_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
    .load_bit9(wr_bit9), .shift_en(shift_en), .fill(fill),
    .sh(sh), .marker_hit(marker_hit)
  );

  uart9_tx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .roll(roll), .wr_en(wr_en),
    .flag_clr(flag_clr), .marker_hit(marker_hit), .load(load),
    .shift_en(shift_en), .fill(fill), .phase(phase), .shifted(shifted),
    .busy(busy), .finish(finish), .tx_done(tx_done)
  );

  always_comb begin
    unique case (phase)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sh[0];
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart9_tx_chk.sv
module uart9_tx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            roll,
  input logic            wr_en,
  input logic            flag_clr,
  input logic            busy,
  input logic            txd,
  input logic            tx_done,
  input logic            send,
  input logic            data_ph,
  input logic [DATA_W:0] sh
);
  localparam logic [DATA_W-1:0] SENTINEL = DATA_W'(1);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!send && !data_ph) |-> txd);

  // R3
  start_on_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send) |-> $past(roll));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && $past(send) && !$past(roll)) |-> $stable(txd));

  // R5
  done_on_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> ($past(roll) && !busy && txd));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !flag_clr) |=> tx_done);

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && !roll) |=> $stable(sh));

  // R8
  sentinel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(send) |-> ($past(sh[DATA_W:1]) == SENTINEL));
endmodule

bind uart9_tx uart9_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .roll(roll), .wr_en(wr_en),
  .flag_clr(flag_clr), .busy(busy), .txd(txd), .tx_done(tx_done),
  .send(send), .data_ph(data_ph), .sh(sh)
);

// File: tb/tb_uart9_tx.sv
module tb_uart9_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIVN = 16;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit9 = 1'b0;
  logic       flag_clr = 1'b0;
  logic       txd, busy, tx_done;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  int cyc = 0;
  bit rolled;
  int first_ticks;

  typedef struct packed {
    logic [7:0] d;
    logic       b9;
    logic [4:0] pre;
    logic       align;
    logic [5:0] stall;
    logic       b2b;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h55, 1'b0, 5'd3,  1'b0, 6'd0,  1'b0},
    '{8'hA5, 1'b1, 5'd7,  1'b0, 6'd40, 1'b0},
    '{8'h00, 1'b0, 5'd0,  1'b1, 6'd0,  1'b0},
    '{8'hFF, 1'b1, 5'd11, 1'b0, 6'd0,  1'b0},
    '{8'h00, 1'b1, 5'd0,  1'b0, 6'd0,  1'b1},
    '{8'h80, 1'b0, 5'd2,  1'b0, 6'd3,  1'b0},
    '{8'h01, 1'b0, 5'd15, 1'b1, 6'd0,  1'b0},
    '{8'h3C, 1'b1, 5'd0,  1'b0, 6'd0,  1'b1}
  };

  uart9_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .flag_clr(flag_clr),
    .txd(txd), .busy(busy), .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // drive one clock cycle; sample after the following falling edge
  task automatic step(input logic tk, input logic we, input logic clr,
                      input logic [7:0] d, input logic b9);
    baud_tick = tk; wr_en = we; flag_clr = clr; wr_data = d; wr_bit9 = b9;
    rolled = tk && ((tcnt % DIVN) == DIVN - 1);
    if (tk) tcnt++;
    @(negedge clk);
    baud_tick = 1'b0; wr_en = 1'b0; flag_clr = 1'b0;
  endtask

  function automatic logic line_bit(input int k, input logic [7:0] d, input logic b9);
    if (k == 0)      return 1'b1;
    else if (k == 1) return 1'b0;
    else if (k <= 9) return d[k-2];
    else if (k == 10) return b9;
    else             return 1'b1;
  endfunction

  task automatic run_frame(input vec_t v);
    int k = 0;
    int ticks = 0;
    logic exp_l;
    for (int i = 0; i < v.pre; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    end
    if (v.align) begin
      while ((tcnt % DIVN) != DIVN - 1) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    end
    step(v.align, 1'b1, 1'b0, v.d, v.b9);
    check(busy === 1'b1, "R3 busy after write", busy, 1);
    check(txd === 1'b1, "R2 idle before start", txd, 1);
    if (v.stall != 0) begin
      for (int i = 0; i < v.stall; i++) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
      check(txd === 1'b1, "R3 no start without ticks", txd, 1);
      check(busy === 1'b1, "R3 busy held without ticks", busy, 1);
    end
    while (k < 11) begin
      step(1'b1, (k == 5), 1'b0, ~v.d, ~v.b9);
      ticks++;
      if (rolled) begin
        k++;
        if (k == 1) first_ticks = ticks;
        if (k == 10) check(busy === 1'b1, "R8 no early end", busy, 1);
        if (k < 10) check(busy === 1'b1, "R3 busy in frame", busy, 1);
      end
      exp_l = line_bit(k, v.d, v.b9);
      if (k >= 6 && k <= 10)
        check(txd === exp_l, "R7 bits kept after ignored write", txd, exp_l);
      else if (k >= 1 && k < 11)
        check(txd === exp_l, "R4 line bit", txd, exp_l);
      else
        check(txd === exp_l, "R2 line high", txd, exp_l);
      step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    end
    check(tx_done === 1'b1, "R5 done at 11th wrap", tx_done, 1);
    check(busy === 1'b0, "R5 busy low at end", busy, 0);
    check(txd === 1'b1, "R5 stop bit high", txd, 1);
    if (v.align || v.b2b)
      check(first_ticks == DIVN, "R9/R3 start one bit time later", first_ticks, DIVN);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(txd === 1'b1, "R1 txd in reset", txd, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd === 1'b1, "R1 txd after reset", txd, 1);
    check(busy === 1'b0, "R1 busy after reset", busy, 0);
    check(tx_done === 1'b0, "R1 done after reset", tx_done, 0);

    // R2: idle ticks keep the line high
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      check(txd === 1'b1, "R2 idle line", txd, 1);
    end

    for (int n = 0; n < NV; n++) begin
      run_frame(VEC[n]);
      if (!(n + 1 < NV && VEC[n+1].b2b)) begin
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        check(tx_done === 1'b1, "R6 done sticky", tx_done, 1);
        check(txd === 1'b1, "R2 line high after frame", txd, 1);
        step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        check(tx_done === 1'b0, "R6 done cleared", tx_done, 0);
      end
    end

    // R6: completion wins over a clear in the same cycle
    begin
      vec_t v = '{8'h5A, 1'b0, 5'd0, 1'b0, 6'd0, 1'b0};
      step(1'b0, 1'b1, 1'b0, v.d, v.b9);
      while (busy) begin
        if (((tcnt % DIVN) == DIVN - 1) && busy) step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
        else step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      end
      check(tx_done === 1'b1, "R6 set beats clear", tx_done, 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule